// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer on a plain 32-bit register bus with a write strobe, a word address, write data and combinational read data. Software configures it through a mode register and a counter control register. Each of these takes a write only when the write carries that register's own key pattern. Once enabled, a 24-bit down-counter decrements on every tick of a selectable prescaler. Software keeps the system alive by writing one exact restart value, which reloads the counter. If no restart arrives before the counter hits zero, the block latches a timeout status bit. Depending on the mode bits, it then drives an interrupt level, a reset pulse of selectable width, or both.

The reload value is 12 bits wide. It forms the upper bits of the counter, and the lower fill bits (12 by default) are loaded as ones. A timeout therefore takes (reload·2^FILL_W + 2^FILL_W − 1) prescaler ticks after a restart. The fill width is a parameter, so a test can shorten the timeout windows.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the watchdog is disabled. The mode fields are zero, the prescaler select is 0, the reload field is 0xFFF, the status bit is 0, and both irq and rst_pulse are low.
- R2: A write to address 0x0 updates the mode fields only when data bits [23:12] equal 0xABC. Otherwise it is ignored. The fields are bit 0 enable, bit 1 reset-output enable, bit 2 interrupt enable, and bits [5:4] pulse-width code. Readback returns these bits with every other bit read as zero.
- R3: A write to address 0x4 updates the control fields only when data bits [25:14] equal 0x248. Otherwise it is ignored. The fields are bits [13:2] reload value and bits [1:0] prescaler select. Readback returns these bits with every other bit read as zero.
- R4: Prescaler select codes 0, 1, 2 and 3 divide the clock by 8, 64, 512 and 4096. After a restart, the status bit sets exactly N·D clock edges later, where N = reload·2^FILL_W + 2^FILL_W − 1 and D is the divisor.
- R5: Writing exactly 0x00001999 to address 0x8 reloads the counter, clears the prescaler and clears the status bit. Any other value written there has no effect. Address 0x8 reads as zero.
- R6: Address 0xC bit 0 reads the timeout status. It is set in the cycle the counter reaches zero.
- R7: irq is a level equal to the status bit while interrupt enable is set, and low otherwise.
- R8: If reset-output enable is set at the moment of timeout, rst_pulse is high for 2, 4, 8 or 16 clock cycles for width codes 0, 1, 2 and 3. If it is clear, rst_pulse stays low.
- R9: While enable is clear, the counter and prescaler hold their values. After a keyed re-enable, counting resumes from where it stopped.
- R10: After timeout the counter stays at zero and the status bit stays set until a valid restart. No further reset pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | 4 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq | output | 1 | Timeout interrupt level |
| rst_pulse | output | 1 | Timed reset pulse on timeout |

## Verification
A register write lands on the rising edge that samples wr_en, so its readback is due at the falling edge right after. The status bit is due exactly N·D edges after the edge that took the restart. The bench samples the falling edge one cycle before that point, expecting it clear, and the falling edge at that point, expecting it set. The reset pulse starts on that same edge and is counted in high samples over the falling edges that follow. In the freeze case, the edge that takes the disabling write still counts and the edge that takes the re-enabling write does not, and the expected expiry point is shifted accordingly. The bench runs with a fill width of 4 so that every prescaler setting reaches a full timeout.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int ADDR_W = 4,
  parameter int RV_W   = 12,
  parameter int FILL_W = 12,
  parameter logic [11:0] MODE_KEY = 12'hABC,
  parameter logic [11:0] CTRL_KEY = 12'h248,
  parameter logic [31:0] KICK_VAL = 32'h0000_1999
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq,
  output logic              rst_pulse
);
  localparam int CNT_W = RV_W + FILL_W;
  localparam int PRE_W = 12;

  logic              en_q, rsten_q, irqen_q, expired_q;
  logic [1:0]        wsel_q, psel_q;
  logic [RV_W-1:0]   rv_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PRE_W-1:0]  pre_q, div_m1;
  logic [4:0]        pulse_q;

  logic aligned, sel_mode, sel_ctrl, sel_kick, sel_stat;
  logic mode_ok, ctrl_ok, kick_hit, run, tick, hit_zero;

  assign aligned  = addr[1:0] == 2'b00;
  assign sel_mode = aligned && addr[ADDR_W-1:2] == 'd0;
  assign sel_ctrl = aligned && addr[ADDR_W-1:2] == 'd1;
  assign sel_kick = aligned && addr[ADDR_W-1:2] == 'd2;
  assign sel_stat = aligned && addr[ADDR_W-1:2] == 'd3;

  assign mode_ok  = wr_en && sel_mode && wdata[23:12] == MODE_KEY;
  assign ctrl_ok  = wr_en && sel_ctrl && wdata[25:14] == CTRL_KEY;
  assign kick_hit = wr_en && sel_kick && wdata == KICK_VAL;

  always_comb begin
    case (psel_q)
      2'd0:    div_m1 = 12'd7;
      2'd1:    div_m1 = 12'd63;
      2'd2:    div_m1 = 12'd511;
      default: div_m1 = 12'd4095;
    endcase
  end

  assign run      = en_q && !expired_q;
  assign tick     = run && pre_q >= div_m1;
  assign hit_zero = tick && cnt_q == CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      rsten_q <= 1'b0;
      irqen_q <= 1'b0;
      wsel_q  <= 2'd0;
    end else if (mode_ok) begin
      en_q    <= wdata[0];
      rsten_q <= wdata[1];
      irqen_q <= wdata[2];
      wsel_q  <= wdata[5:4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q   <= '1;
      psel_q <= 2'd0;
    end else if (ctrl_ok) begin
      rv_q   <= wdata[RV_W+1:2];
      psel_q <= wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '1;
      pre_q     <= '0;
      expired_q <= 1'b0;
    end else if (kick_hit) begin
      cnt_q     <= {rv_q, {FILL_W{1'b1}}};
      pre_q     <= '0;
      expired_q <= 1'b0;
    end else if (run) begin
      if (tick) begin
        pre_q <= '0;
        cnt_q <= cnt_q - CNT_W'(1);
        if (hit_zero) expired_q <= 1'b1;
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pulse_q <= '0;
    else if (hit_zero && rsten_q) pulse_q <= 5'd2 << wsel_q;
    else if (pulse_q != '0)      pulse_q <= pulse_q - 5'd1;
  end

  assign rst_pulse = pulse_q != '0;
  assign irq       = expired_q && irqen_q;

  always_comb begin
    rdata = '0;
    if (sel_mode)      rdata[5:0] = {wsel_q, 1'b0, irqen_q, rsten_q, en_q};
    else if (sel_ctrl) rdata[RV_W+1:0] = {rv_q, psel_q};
    else if (sel_stat) rdata[0] = expired_q;
  end

  AST_MODE_KEY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_mode && wdata[23:12] != MODE_KEY) |=> $stable({en_q, rsten_q, irqen_q, wsel_q})); // R2
  AST_CTRL_KEY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_ctrl && wdata[25:14] != CTRL_KEY) |=> $stable({rv_q, psel_q})); // R3
  AST_KICK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    kick_hit |=> (!expired_q && cnt_q == {$past(rv_q), {FILL_W{1'b1}}} && pre_q == '0)); // R5
  AST_BAD_KICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_kick && wdata != KICK_VAL && !run) |=> ($stable(cnt_q) && $stable(expired_q))); // R5
  AST_EXPIRY_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired_q) |-> cnt_q == '0); // R6
  AST_PULSE_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pulse) |-> expired_q); // R8
  AST_PULSE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q <= 5'd16); // R8
  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !kick_hit) |=> ($stable(cnt_q) && $stable(pre_q))); // R9
  AST_STAYS_EXPIRED: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_q && !kick_hit) |=> (expired_q && cnt_q == '0)); // R10
endmodule

// File: tb/tb_keyed_wdt.sv
module tb_keyed_wdt;
  localparam int PERIOD = 10;
  localparam int FILL   = 4;
  localparam logic [31:0] MKEY = 32'h00AB_C000;
  localparam logic [31:0] CKEY = 32'h0092_0000;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, rst_pulse;
  int checks = 0, fails = 0;

  logic       m_en, m_rst, m_irq;
  logic [1:0] m_w, m_ps;
  logic [11:0] m_rv;

  keyed_wdt #(.FILL_W(FILL)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .rst_pulse(rst_pulse));

  always #(PERIOD/2) clk = ~clk;

  function automatic int div_of(input logic [1:0] p);
    return 8 << (3 * int'(p));
  endfunction
  function automatic int width_of(input logic [1:0] w);
    return 2 << int'(w);
  endfunction
  function automatic logic [31:0] mode_rd();
    return {26'd0, m_w, 1'b0, m_irq, m_rst, m_en};
  endfunction
  function automatic logic [31:0] ctrl_rd();
    return {18'd0, m_rv, m_ps};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_en = 0; m_rst = 0; m_irq = 0; m_w = 0; m_ps = 0; m_rv = 12'hFFF;
    @(negedge clk);
  endtask

  task automatic timeout_case(input logic [11:0] rv, input logic [1:0] ps,
                              input logic [1:0] w, input logic re, input logic ie);
    logic [31:0] v;
    int n, highs;
    wr(4'h4, CKEY | {18'd0, rv, ps});
    wr(4'h0, MKEY | {26'd0, w, 1'b0, ie, re, 1'b1});
    wr(4'h8, 32'h1999);
    n = (int'(rv) * (1 << FILL) + (1 << FILL) - 1) * div_of(ps);
    repeat (n - 1) @(negedge clk);
    rd(4'hC, v); chk("R4 status one cycle before expiry", v, 0);
    chk("R7 irq before expiry", {31'd0, irq}, 0);
    @(negedge clk);
    rd(4'hC, v); chk("R6 status at expiry", v, 1);
    chk("R7 irq level at expiry", {31'd0, irq}, {31'd0, ie});
    highs = 0;
    for (int i = 0; i < 24; i++) begin
      if (rst_pulse) highs++;
      @(negedge clk);
    end
    chk("R8 reset pulse width", highs, re ? width_of(w) : 0);
    rd(4'hC, v); chk("R10 status held after expiry", v, 1);
    chk("R10 no second pulse", {31'd0, rst_pulse}, 0);
    wr(4'h8, 32'h1998);
    rd(4'hC, v); chk("R5 wrong restart value ignored", v, 1);
    wr(4'h8, 32'h1999);
    rd(4'hC, v); chk("R5 restart clears status", v, 0);
    chk("R7 irq cleared by restart", {31'd0, irq}, 0);
    wr(4'h0, MKEY);
  endtask

  initial begin
    #(PERIOD * 190000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, d;
    void'($urandom(32'd1234));
    do_reset();
    rd(4'h0, v); chk("R1 mode after reset", v, 0);
    rd(4'h4, v); chk("R1 ctrl after reset", v, 32'h0000_3FFC);
    rd(4'hC, v); chk("R1 status after reset", v, 0);
    rd(4'h8, v); chk("R5 restart reads zero", v, 0);
    chk("R1 outputs after reset", {30'd0, irq, rst_pulse}, 0);

    wr(4'h0, 32'h00AB_B037);
    rd(4'h0, v); chk("R2 mode write with wrong key", v, 0);
    wr(4'h4, 32'h0091_8001);
    rd(4'h4, v); chk("R3 ctrl write with wrong key", v, 32'h0000_3FFC);

    for (int i = 0; i < 300; i++) begin
      int kind = int'($urandom_range(0, 1));
      logic good = 1'($urandom_range(0, 1));
      d = $urandom;
      if (kind == 0) begin
        d[0] = 1'b0;
        if (good) d[23:12] = 12'hABC; else if (d[23:12] == 12'hABC) d[12] = 1'b0;
        wr(4'h0, d);
        if (good) begin m_en = 0; m_rst = d[1]; m_irq = d[2]; m_w = d[5:4]; end
        rd(4'h0, v); chk("R2 random mode write", v, mode_rd());
      end else begin
        if (good) d[25:14] = 12'h248; else if (d[25:14] == 12'h248) d[14] = 1'b1;
        wr(4'h4, d);
        if (good) begin m_rv = d[13:2]; m_ps = d[1:0]; end
        rd(4'h4, v); chk("R3 random ctrl write", v, ctrl_rd());
      end
    end

    do_reset();
    timeout_case(12'd3, 2'd0, 2'd3, 1'b1, 1'b1);
    timeout_case(12'd1, 2'd1, 2'd0, 1'b1, 1'b0);
    timeout_case(12'd0, 2'd2, 2'd1, 1'b0, 1'b1);
    timeout_case(12'd0, 2'd3, 2'd2, 1'b1, 1'b1);

    // R9: freeze and resume, total 504 counting edges for reload 3 / divide 8
    wr(4'h4, CKEY | 32'h0000_000C);
    wr(4'h0, MKEY | 32'h1);
    wr(4'h8, 32'h1999);
    repeat (100) @(negedge clk);
    wr(4'h0, MKEY);
    repeat (300) @(negedge clk);
    rd(4'hC, v); chk("R9 no expiry while disabled", v, 0);
    wr(4'h0, MKEY | 32'h1);
    repeat (402) @(negedge clk);
    rd(4'hC, v); chk("R9 resumed count not yet done", v, 0);
    @(negedge clk);
    rd(4'hC, v); chk("R9 resumed count expires on time", v, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule